// File: doc/BRIEF.md
# Dual-Clock 9-Bit FIFO with Reset-Selected Auxiliary Enable

This block is a first-in first-out buffer of 9-bit words. It has a write port and a read port, and each port runs on its own clock. The writer sees a full flag and an almost-full flag, both computed in the write clock domain. The reader sees an empty flag and an almost-empty flag, both computed in the read clock domain. Each pointer crosses into the other domain as a Gray code through a chain of synchroniser flops.

The auxiliary write pin `wr_aux` has one of two roles. The block samples its level while reset is held and keeps that role until the next reset. If `wr_aux` is high during reset, it becomes a second write enable that must be asserted together with `wr_en`. If `wr_aux` is low during reset, it becomes a strobe that routes a `wr_en` write into the two threshold offset registers instead of into the FIFO.

A read needs both read enables asserted at once. Output enable gates the data port. Depth is a power-of-two parameter from 256 to 8192 words. For a two-channel device, instantiate the block twice.

Top module: `twoclk_fifo9`

## Requirements
- R1: While `rst_n` is low and after it is released, `flag_empty` and `flag_aempty` read 1, `flag_full` and `flag_afull` read 0, and `q_out` reads zero while `out_en` is 1.
- R2: If `wr_aux` is 1 on the last write-clock edge of reset, a word is stored on a write-clock rising edge only when `wr_en` and `wr_aux` are both 1 and `flag_full` is 0. `wr_en` alone stores nothing.
- R3: If `wr_aux` is 0 on the last write-clock edge of reset, a write-clock edge with `wr_en`=1 and `wr_aux`=1 loads the low 8+ bits of `din` into an offset register and stores nothing in the FIFO. Successive loads go to the almost-empty offset, then to the almost-full offset, and then alternate. A write-clock edge with `wr_en`=1 and `wr_aux`=0 stores a data word.
- R4: A word is read on a read-clock rising edge only when `rd_en_a` and `rd_en_b` are both 1 and `flag_empty` is 0. The word appears on `q_out` after that edge, and words leave in the order they were written. With only one read enable asserted, `q_out` holds its value.
- R5: A write while `flag_full` is 1 is dropped and the stored words are unchanged. A read while `flag_empty` is 1 leaves `q_out` unchanged.
- R6: `flag_full` rises on the write-clock edge that brings the write-domain count to DEPTH. After a read from a full FIFO, it falls no later than the third write-clock rising edge after that read edge.
- R7: `flag_empty` rises on the read-clock edge of the read that takes the last word. After a write into an empty FIFO, it falls no later than the third read-clock rising edge after that write edge.
- R8: `flag_aempty` is 1 exactly when the read-domain count is at or below the almost-empty offset. The offset is 7 after reset.
- R9: `flag_afull` is 1 exactly when the write-domain count is at or above DEPTH minus the almost-full offset. The offset is 7 after reset.
- R10: `q_drive` follows `out_en`. When `out_en` is 0, `q_out` reads zero.
- R11: Write and read enables asserted while `rst_n` is low move no data. After reset the FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Active-low reset shared by both domains; role of `wr_aux` sampled while low |
| din | input | 9 | Write data, or offset value in load role |
| wr_en | input | 1 | Primary write enable |
| wr_aux | input | 1 | Second write enable or offset-load strobe, chosen at reset |
| rd_en_a | input | 1 | First read enable |
| rd_en_b | input | 1 | Second read enable |
| out_en | input | 1 | Output enable for `q_out` |
| q_out | output | 9 | Read data, zero when output is disabled |
| q_drive | output | 1 | High when `q_out` is being driven |
| flag_empty | output | 1 | FIFO empty, read domain |
| flag_aempty | output | 1 | Almost empty, read domain |
| flag_afull | output | 1 | Almost full, write domain |
| flag_full | output | 1 | FIFO full, write domain |

## Verification
Read data is due on the first read-clock edge after the enables are applied. The bench samples `q_out` on the next falling read edge, and a scoreboard queue pops there to compare in order. Flags in their own domain change on the same edge as the transfer, so the bench checks `flag_full` and `flag_empty` on the falling edge right after the word that fills or drains the FIFO. A pointer needs up to three edges of the far clock to reach the other domain. For that reason the bench waits exactly three far-side rising edges before it checks the full and empty release times, and it waits several idle cycles of both clocks before it checks the threshold flags against its own count.

// File: rtl/fifo9_pkg.sv
`timescale 1ns/1ps
package fifo9_pkg;
  localparam int WORD_W  = 9;
  localparam int PMAX    = 16;
  localparam int DEF_OFF = 7;

  typedef logic [PMAX-1:0] pword_t;

  // role of the auxiliary write pin, latched during reset
  typedef enum logic {ROLE_LOAD = 1'b0, ROLE_WEN2 = 1'b1} aux_role_e;

  function automatic pword_t to_gray(pword_t b);
    return b ^ (b >> 1);
  endfunction

  function automatic pword_t from_gray(pword_t g);
    pword_t b;
    b[PMAX-1] = g[PMAX-1];
    for (int i = PMAX - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // modular distance between two pointers; caller keeps the low bits
  function automatic pword_t ptr_gap(pword_t lead, pword_t trail);
    return lead - trail;
  endfunction
endpackage

// File: rtl/fifo9_sync.sv
`timescale 1ns/1ps
module fifo9_sync #(
  parameter int W      = 9,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= {stage_q[STAGES-2:0], d};
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/fifo9_store.sv
`timescale 1ns/1ps
module fifo9_store #(
  parameter int AW = 8,
  parameter int W  = 9
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= mem_q[raddr];
  end

  // R4
  rdata_hold_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    !re |=> $stable(rdata));
endmodule

// File: rtl/fifo9_wside.sv
`timescale 1ns/1ps
module fifo9_wside import fifo9_pkg::*; #(
  parameter int AW   = 8,
  parameter int SYNC = 2
) (
  input  logic          wclk,
  input  logic          rst_n,
  input  logic [WORD_W-1:0] din,
  input  logic          wr_en,
  input  logic          wr_aux,
  input  logic [AW:0]   rgray,
  output logic [AW:0]   wgray,
  output logic [AW-1:0] waddr,
  output logic          wr_fire,
  output logic [AW-1:0] ae_off,
  output logic          full,
  output logic          almost_full
);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] FULL_CNT = {1'b1, {AW{1'b0}}};

  aux_role_e     role_q;
  logic [PW-1:0] wbin_q, wbin_nxt, wgray_nxt, rgray_s, rbin_s, used, af_thr;
  logic [AW-1:0] af_off_q, ae_off_q;
  logic          load_sel_q;
  logic          wr_req, ld_req;
  pword_t        g_tmp, b_tmp, u_tmp;

  // role sampled on every write-clock edge while reset is held
  always_ff @(posedge wclk) begin
    if (!rst_n) role_q <= wr_aux ? ROLE_WEN2 : ROLE_LOAD;
  end

  fifo9_sync #(.W(PW), .STAGES(SYNC)) u_rsync (
    .clk(wclk), .rst_n(rst_n), .d(rgray), .q(rgray_s)
  );

  assign wr_req  = wr_en & ((role_q == ROLE_WEN2) ? wr_aux : ~wr_aux);
  assign ld_req  = wr_en & wr_aux & (role_q == ROLE_LOAD);
  assign wr_fire = wr_req & ~full;

  always_comb begin
    wbin_nxt  = wbin_q + PW'(1);
    g_tmp     = to_gray(pword_t'(wbin_nxt));
    wgray_nxt = g_tmp[PW-1:0];
    b_tmp     = from_gray(pword_t'(rgray_s));
    rbin_s    = b_tmp[PW-1:0];
    u_tmp     = ptr_gap(pword_t'(wbin_q), pword_t'(rbin_s));
    used      = u_tmp[PW-1:0];
    af_thr    = FULL_CNT - {1'b0, af_off_q};
  end

  assign full        = (used == FULL_CNT);
  assign almost_full = (used >= af_thr);

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wbin_q <= '0;
      wgray  <= '0;
    end else if (wr_fire) begin
      wbin_q <= wbin_nxt;
      wgray  <= wgray_nxt;
    end
  end

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      ae_off_q   <= AW'(DEF_OFF);
      af_off_q   <= AW'(DEF_OFF);
      load_sel_q <= 1'b0;
    end else if (ld_req) begin
      if (!load_sel_q) ae_off_q <= AW'(din);
      else             af_off_q <= AW'(din);
      load_sel_q <= ~load_sel_q;
    end
  end

  assign waddr  = wbin_q[AW-1:0];
  assign ae_off = ae_off_q;

  // R5
  no_write_when_full_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    (full && wr_req) |=> $stable(wbin_q));
  // R6
  used_le_depth_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    used <= FULL_CNT);
  // R7
  wgray_step_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    $onehot0(wgray ^ $past(wgray)));
  // R2
  role_hold_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    $stable(role_q));
endmodule

// File: rtl/fifo9_rside.sv
`timescale 1ns/1ps
module fifo9_rside import fifo9_pkg::*; #(
  parameter int AW   = 8,
  parameter int SYNC = 2
) (
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          rd_en_a,
  input  logic          rd_en_b,
  input  logic [AW:0]   wgray,
  input  logic [AW-1:0] ae_off,
  output logic [AW:0]   rgray,
  output logic [AW-1:0] raddr,
  output logic          rd_fire,
  output logic          empty,
  output logic          almost_empty
);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] FULL_CNT = {1'b1, {AW{1'b0}}};

  logic [PW-1:0] rbin_q, rbin_nxt, rgray_nxt, wgray_s, wbin_s, held;
  logic          rd_req;
  pword_t        g_tmp, b_tmp, h_tmp;

  fifo9_sync #(.W(PW), .STAGES(SYNC)) u_wsync (
    .clk(rclk), .rst_n(rst_n), .d(wgray), .q(wgray_s)
  );

  assign rd_req  = rd_en_a & rd_en_b;
  assign rd_fire = rd_req & ~empty;

  always_comb begin
    rbin_nxt  = rbin_q + PW'(1);
    g_tmp     = to_gray(pword_t'(rbin_nxt));
    rgray_nxt = g_tmp[PW-1:0];
    b_tmp     = from_gray(pword_t'(wgray_s));
    wbin_s    = b_tmp[PW-1:0];
    h_tmp     = ptr_gap(pword_t'(wbin_s), pword_t'(rbin_q));
    held      = h_tmp[PW-1:0];
  end

  assign empty        = (held == '0);
  assign almost_empty = (held <= {1'b0, ae_off});

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rbin_q <= '0;
      rgray  <= '0;
    end else if (rd_fire) begin
      rbin_q <= rbin_nxt;
      rgray  <= rgray_nxt;
    end
  end

  assign raddr = rbin_q[AW-1:0];

  // R5
  no_read_when_empty_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    (empty && rd_req) |=> $stable(rbin_q));
  // R7
  held_le_depth_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    held <= FULL_CNT);
  // R4
  rgray_step_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    $onehot0(rgray ^ $past(rgray)));
endmodule

// File: rtl/twoclk_fifo9.sv
`timescale 1ns/1ps
module twoclk_fifo9 import fifo9_pkg::*; #(
  parameter int DEPTH       = 256,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] din,
  input  logic              wr_en,
  input  logic              wr_aux,
  input  logic              rd_en_a,
  input  logic              rd_en_b,
  input  logic              out_en,
  output logic [WORD_W-1:0] q_out,
  output logic              q_drive,
  output logic              flag_empty,
  output logic              flag_aempty,
  output logic              flag_afull,
  output logic              flag_full
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [PW-1:0]     wgray, rgray;
  logic [AW-1:0]     waddr, raddr, ae_off;
  logic              wr_fire, rd_fire;
  logic [WORD_W-1:0] rdata;

  fifo9_wside #(.AW(AW), .SYNC(SYNC_STAGES)) u_wside (
    .wclk(wclk), .rst_n(rst_n), .din(din), .wr_en(wr_en), .wr_aux(wr_aux),
    .rgray(rgray), .wgray(wgray), .waddr(waddr), .wr_fire(wr_fire),
    .ae_off(ae_off), .full(flag_full), .almost_full(flag_afull)
  );

  fifo9_rside #(.AW(AW), .SYNC(SYNC_STAGES)) u_rside (
    .rclk(rclk), .rst_n(rst_n), .rd_en_a(rd_en_a), .rd_en_b(rd_en_b),
    .wgray(wgray), .ae_off(ae_off), .rgray(rgray), .raddr(raddr),
    .rd_fire(rd_fire), .empty(flag_empty), .almost_empty(flag_aempty)
  );

  fifo9_store #(.AW(AW), .W(WORD_W)) u_store (
    .wclk(wclk), .we(wr_fire), .waddr(waddr), .wdata(din),
    .rclk(rclk), .rst_n(rst_n), .re(rd_fire), .raddr(raddr), .rdata(rdata)
  );

  assign q_out   = out_en ? rdata : '0;
  assign q_drive = out_en;
endmodule

// File: tb/twoclk_fifo9_test.sv
`timescale 1ns/1ps
module twoclk_fifo9_test;
  localparam int DEPTH = 256;

  logic       wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
  logic [8:0] din = '0;
  logic       wr_en = 1'b0, wr_aux = 1'b0, rd_en_a = 1'b0, rd_en_b = 1'b0, out_en = 1'b1;
  logic [8:0] q_out;
  logic       q_drive, flag_empty, flag_aempty, flag_afull, flag_full;

  int         n_chk = 0, n_bad = 0;
  logic       role_wen2 = 1'b1;
  logic       done = 1'b0;
  logic [8:0] exp_q [$];

  always #2.5 wclk = ~wclk;
  always #3.5 rclk = ~rclk;

  twoclk_fifo9 #(.DEPTH(DEPTH)) uut (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .din(din), .wr_en(wr_en),
    .wr_aux(wr_aux), .rd_en_a(rd_en_a), .rd_en_b(rd_en_b), .out_en(out_en),
    .q_out(q_out), .q_drive(q_drive), .flag_empty(flag_empty),
    .flag_aempty(flag_aempty), .flag_afull(flag_afull), .flag_full(flag_full)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [8:0] pat(input int i);
    return 9'((i * 37 + 5) % 512);
  endfunction

  task automatic settle();
    repeat (5) @(negedge wclk);
    repeat (5) @(negedge rclk);
  endtask

  task automatic apply_reset(input logic aux_level);
    rst_n = 1'b0; wr_aux = aux_level; wr_en = 1'b1; din = 9'h1F0;
    rd_en_a = 1'b1; rd_en_b = 1'b1;
    repeat (6) @(negedge wclk);
    repeat (3) @(negedge rclk);
    @(negedge wclk);
    rst_n = 1'b1; wr_en = 1'b0; wr_aux = 1'b0; rd_en_a = 1'b0; rd_en_b = 1'b0;
    role_wen2 = aux_level;
    exp_q.delete();
    settle();
  endtask

  // driver: presents one write, queues it when the flag allowed it
  task automatic push(input logic [8:0] d);
    logic acc;
    @(negedge wclk);
    din = d; wr_en = 1'b1; wr_aux = role_wen2;
    acc = !flag_full;
    @(negedge wclk);
    wr_en = 1'b0; wr_aux = 1'b0;
    if (acc) exp_q.push_back(d);
  endtask

  // monitor: one read, compares the produced word with the queue head
  task automatic pop_cmp(input string tag);
    logic       had;
    logic [8:0] e;
    @(negedge rclk);
    rd_en_a = 1'b1; rd_en_b = 1'b1;
    had = !flag_empty;
    @(negedge rclk);
    rd_en_a = 1'b0; rd_en_b = 1'b0;
    if (had) begin
      if (exp_q.size() == 0) chk({tag, " extra word"}, 32'(q_out), 32'h3FF);
      else begin
        e = exp_q.pop_front();
        chk(tag, 32'(q_out), 32'(e));
      end
    end
  endtask

  task automatic load_off(input logic [8:0] v);
    @(negedge wclk);
    din = v; wr_en = 1'b1; wr_aux = 1'b1;
    @(negedge wclk);
    wr_en = 1'b0; wr_aux = 1'b0;
  endtask

  initial begin
    #600000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [8:0] held;
    apply_reset(1'b1);
    chk("R1 empty", 32'(flag_empty), 1);
    chk("R1 aempty", 32'(flag_aempty), 1);
    chk("R1 full", 32'(flag_full), 0);
    chk("R1 afull", 32'(flag_afull), 0);
    chk("R1 q_out", 32'(q_out), 0);
    chk("R11 nothing stored in reset", 32'(flag_empty), 1);

    // R2: primary enable alone stores nothing
    @(negedge wclk); din = 9'h0AA; wr_en = 1'b1; wr_aux = 1'b0;
    @(negedge wclk); wr_en = 1'b0;
    settle();
    chk("R2 single enable ignored", 32'(flag_empty), 1);

    // R7: empty release within three read edges of the write edge
    push(pat(0));
    repeat (3) @(posedge rclk);
    @(negedge rclk);
    chk("R7 empty release", 32'(flag_empty), 0);
    for (int i = 1; i < 10; i++) push(pat(i));
    settle();
    chk("R8 aempty at 10", 32'(flag_aempty), 0);
    pop_cmp("R4 order");
    pop_cmp("R4 order");
    settle();
    chk("R8 aempty at 8", 32'(flag_aempty), 0);
    pop_cmp("R4 order");
    settle();
    chk("R8 aempty at 7", 32'(flag_aempty), 1);

    // R4: one read enable only
    held = q_out;
    @(negedge rclk); rd_en_a = 1'b1; rd_en_b = 1'b0;
    @(negedge rclk); rd_en_a = 1'b0;
    settle();
    chk("R4 single read enable", 32'(q_out), 32'(held));
    for (int i = 0; i < 7; i++) pop_cmp("R4 order");
    chk("R7 empty on last read", 32'(flag_empty), 1);

    // R5: read while empty
    held = q_out;
    @(negedge rclk); rd_en_a = 1'b1; rd_en_b = 1'b1;
    @(negedge rclk); rd_en_a = 1'b0; rd_en_b = 1'b0;
    settle();
    chk("R5 read when empty", 32'(q_out), 32'(held));

    // R10
    @(negedge rclk); out_en = 1'b0;
    #1;
    chk("R10 drive off", 32'(q_drive), 0);
    chk("R10 zero when off", 32'(q_out), 0);
    @(negedge rclk); out_en = 1'b1;
    #1;
    chk("R10 drive on", 32'(q_drive), 1);

    // fill toward full
    for (int i = 0; i < DEPTH - 8; i++) push(pat(100 + i));
    settle();
    chk("R9 afull below threshold", 32'(flag_afull), 0);
    push(pat(400));
    settle();
    chk("R9 afull at threshold", 32'(flag_afull), 1);
    for (int i = 0; i < 6; i++) push(pat(401 + i));
    settle();
    chk("R6 not full at DEPTH-1", 32'(flag_full), 0);
    push(pat(410));
    chk("R6 full on filling write", 32'(flag_full), 1);
    push(9'h1AA);
    chk("R5 write when full dropped", 32'(exp_q.size()), DEPTH);

    // R6: full release timing
    @(negedge rclk); rd_en_a = 1'b1; rd_en_b = 1'b1;
    @(posedge rclk);
    #1; rd_en_a = 1'b0; rd_en_b = 1'b0;
    repeat (3) @(posedge wclk);
    @(negedge wclk);
    chk("R6 full release", 32'(flag_full), 0);
    chk("R4 order first after full", 32'(q_out), 32'(exp_q.pop_front()));
    while (exp_q.size() > 0) pop_cmp("R5 drain after full");
    chk("R7 empty after drain", 32'(flag_empty), 1);

    // load role
    apply_reset(1'b0);
    load_off(9'd3);
    load_off(9'd5);
    settle();
    chk("R3 loads not stored", 32'(flag_empty), 1);
    for (int i = 0; i < 3; i++) push(pat(600 + i));
    settle();
    chk("R3 loaded aempty offset at 3", 32'(flag_aempty), 1);
    push(pat(603));
    settle();
    chk("R3 loaded aempty offset at 4", 32'(flag_aempty), 0);
    for (int i = 0; i < DEPTH - 10; i++) push(pat(700 + i));
    settle();
    chk("R3 loaded afull offset at 250", 32'(flag_afull), 0);
    push(pat(999));
    settle();
    chk("R3 loaded afull offset at 251", 32'(flag_afull), 1);
    while (exp_q.size() > 0) pop_cmp("R3 data writes in load role");
    chk("R3 empty after drain", 32'(flag_empty), 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule